// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

Each core of a multi-core cluster owns one copy of this block. Other cores, or a routing fabric outside the block, post interrupt requests by writing bits into a 32-bit pending word through a write-only "post" register. The owning core acknowledges requests by writing bits to a write-only "ack" register. A 32-bit mask word selects which pending bits may raise the core's interrupt line. Eight 32-bit mailbox words let a sender leave a message for the core.

The interrupt line does not follow the pending and mask words continuously. A post write can only raise it, and only when some pending bit is also unmasked once the write has taken effect. An ack write can only drop it, and only when the pending word is then empty and the mask is nonzero. All other accesses leave the line unchanged, including writes to the mask. The register port is a single-cycle 32-bit write port with a combinational read path, addressed by an 8-bit byte offset.

Top module: `ipi_core_regs`

## Requirements
- R1: Reset clears the pending word, the mask word, all eight mailbox words and `irq`. After reset, reads of offsets 0x00, 0x04 and 0x20 return zero.
- R2: A write to the post register (offset 0x08) ORs `wdata` into the pending word. If (pending AND mask) is nonzero after the update, `irq` is 1 in the cycle after the write. The pending word reads back at offset 0x00.
- R3: A post write that leaves (pending AND mask) equal to zero does not change `irq`.
- R4: A write to the ack register (offset 0x0C) clears the pending bits that are set in `wdata`. `irq` drops in the cycle after the write only if the pending word is then zero and the mask is nonzero. Otherwise `irq` keeps its value.
- R5: A write to the mask register (offset 0x04) replaces the mask word. The mask word reads back at 0x04. Writes to any offset other than 0x08 and 0x0C never change `irq`.
- R6: A write to offset 0x00 leaves the pending word unchanged. It raises `guest_err` for exactly the one cycle after the write.
- R7: Reads of offsets 0x08 and 0x0C return zero.
- R8: Offsets 0x20 through 0x3C hold eight read/write mailbox words. The word index is (offset − 0x20) >> 2.
- R9: Offsets outside 0x00, 0x04, 0x08, 0x0C and 0x20–0x3C (for example 0x10, 0x3D and 0x40) read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt line to the owning core |
| guest_err | output | 1 | One-cycle flag after an illegal write to the pending word |

## Verification
The interrupt line is state in its own right: a post or ack write decided wrongly shows on `irq` one cycle later, and the error persists until the next post or ack write. A corrupted pending or mask word may not move `irq` at all. Such corruption shows only when that word is read back at its offset, or when a later post or ack write makes the wrong decision. For this reason the sequences interleave readbacks with post, ack and mask writes. Mailbox index or decode faults show on the next read of an aliased or out-of-range offset.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int OFF_PEND  = 'h00;
   localparam int OFF_MASK  = 'h04;
   localparam int OFF_POST  = 'h08;
   localparam int OFF_ACK   = 'h0C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PEND,
      SEL_MASK,
      SEL_POST,
      SEL_ACK,
      SEL_MBOX
   } reg_sel_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
   parameter int ADDR_W    = 8,
   parameter int MBOX_N    = 8,
   parameter int MBOX_BASE = 'h20,
   localparam int IDX_W    = (MBOX_N > 1) ? $clog2(MBOX_N) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output ipi_pkg::reg_sel_e sel,
   output logic [IDX_W-1:0]  mbox_idx
);
   import ipi_pkg::*;

   localparam logic [ADDR_W-1:0] MB_LO = ADDR_W'(MBOX_BASE);
   localparam logic [ADDR_W-1:0] MB_HI = ADDR_W'(MBOX_BASE + 4 * (MBOX_N - 1));

   logic [ADDR_W-1:0] mb_off;

   assign mb_off   = addr - MB_LO;
   assign mbox_idx = mb_off[IDX_W+1:2];

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(OFF_PEND))      sel = SEL_PEND;
      else if (addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
      else if (addr == ADDR_W'(OFF_POST)) sel = SEL_POST;
      else if (addr == ADDR_W'(OFF_ACK))  sel = SEL_ACK;
      else if (addr >= MB_LO && addr <= MB_HI) sel = SEL_MBOX;
   end
endmodule

// File: rtl/ipi_status_irq.sv
module ipi_status_irq #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_wr,
   input  logic              ack_wr,
   input  logic              mask_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] pend_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              irq_q
);
   logic [DATA_W-1:0] pend_d;
   logic              irq_d;

   always_comb begin
      pend_d = pend_q;
      irq_d  = irq_q;
      if (post_wr) begin
         pend_d = pend_q | wdata;
         if ((pend_d & mask_q) != '0) irq_d = 1'b1;
      end else if (ack_wr) begin
         pend_d = pend_q & ~wdata;
         if (pend_d == '0 && mask_q != '0) irq_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         irq_q  <= irq_d;
         if (mask_wr) mask_q <= wdata;
      end
   end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
   parameter int DATA_W = 32,
   parameter int MBOX_N = 8,
   localparam int IDX_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] word_q [MBOX_N];

   for (genvar g = 0; g < MBOX_N; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                           word_q[g] <= '0;
         else if (wr && idx == IDX_W'(g))      word_q[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < MBOX_N; i++)
         if (idx == IDX_W'(i)) rdata = word_q[i];
   end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int MBOX_N    = 8,
   parameter int MBOX_BASE = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              guest_err
);
   import ipi_pkg::*;

   localparam int IDX_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ipi_core_regs: ADDR_W must be at least 8");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("ipi_core_regs: DATA_W must be positive");
   end
   if (MBOX_N < 1 || MBOX_BASE % 4 != 0 || MBOX_BASE < 'h10) begin : g_bad_mbox
      $error("ipi_core_regs: mailbox base or count invalid");
   end
   if (MBOX_BASE + 4 * MBOX_N > (1 << ADDR_W)) begin : g_bad_fit
      $error("ipi_core_regs: mailbox exceeds address space");
   end

   reg_sel_e          sel;
   logic [IDX_W-1:0]  mbox_idx;
   logic [DATA_W-1:0] pend_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] mbox_rd;
   logic              err_q;

   ipi_addr_decode #(
      .ADDR_W(ADDR_W), .MBOX_N(MBOX_N), .MBOX_BASE(MBOX_BASE)
   ) u_dec (
      .addr(addr), .sel(sel), .mbox_idx(mbox_idx)
   );

   ipi_status_irq #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .post_wr(wr_en && sel == SEL_POST),
      .ack_wr (wr_en && sel == SEL_ACK),
      .mask_wr(wr_en && sel == SEL_MASK),
      .wdata(wdata), .pend_q(pend_q), .mask_q(mask_q), .irq_q(irq)
   );

   ipi_mailbox #(.DATA_W(DATA_W), .MBOX_N(MBOX_N)) u_mbox (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && sel == SEL_MBOX),
      .idx(mbox_idx), .wdata(wdata), .rdata(mbox_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_en && sel == SEL_PEND;
   end
   assign guest_err = err_q;

   always_comb begin
      unique case (sel)
         SEL_PEND: rdata = pend_q;
         SEL_MASK: rdata = mask_q;
         SEL_MBOX: rdata = mbox_rd;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              irq,
   input logic              guest_err,
   input logic [DATA_W-1:0] pend_q,
   input logic [DATA_W-1:0] mask_q
);
   import ipi_pkg::*;

   logic is_post, is_ack, is_mask, is_pend, is_mbox, is_known;
   assign is_post  = addr == ADDR_W'(OFF_POST);
   assign is_ack   = addr == ADDR_W'(OFF_ACK);
   assign is_mask  = addr == ADDR_W'(OFF_MASK);
   assign is_pend  = addr == ADDR_W'(OFF_PEND);
   assign is_mbox  = addr >= ADDR_W'('h20) && addr <= ADDR_W'('h3C);
   assign is_known = is_post || is_ack || is_mask || is_pend || is_mbox;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!irq && pend_q == '0 && mask_q == '0));

   assert_post_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_post && ((pend_q | wdata) & mask_q) != '0) |=> irq);

   assert_post_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_post && ((pend_q | wdata) & mask_q) == '0) |=> $stable(irq));

   assert_ack_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_ack && (pend_q & ~wdata) == '0 && mask_q != '0) |=> !irq);

   assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_ack && !((pend_q & ~wdata) == '0 && mask_q != '0)) |=> $stable(irq));

   assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (is_post || is_ack)) |=> $stable(irq));

   assert_pend_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_pend) |=> (guest_err && pend_q == $past(pend_q)));

   assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && is_pend) |=> !guest_err);

   assert_wo_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_post || is_ack) |-> rdata == '0);

   assert_undecoded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_known |-> rdata == '0);

   assert_undecoded_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_known) |=> ($stable(pend_q) && $stable(mask_q)));
endmodule

bind ipi_core_regs ipi_core_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .irq(irq), .guest_err(guest_err),
   .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/ipi_core_regs_bench.sv
`timescale 1ns/1ps
module ipi_core_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic        guest_err;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ipi_core_regs u_ipi_core_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .guest_err(guest_err)
   );

   // entry: {write, offset, data, expected read, expected irq, requirement}
   localparam int NV = 39;
   localparam logic [77:0] VEC [NV] = '{
      {1'b0, 8'h00, 32'h0,    32'h0,    1'b0, 4'd1},  // R1 pending zero
      {1'b0, 8'h04, 32'h0,    32'h0,    1'b0, 4'd1},  // R1 mask zero
      {1'b0, 8'h20, 32'h0,    32'h0,    1'b0, 4'd1},  // R1 mailbox zero
      {1'b1, 8'h08, 32'h5,    32'h0,    1'b0, 4'd3},  // R3 post, mask 0
      {1'b0, 8'h00, 32'h0,    32'h5,    1'b0, 4'd2},  // R2 readback
      {1'b1, 8'h04, 32'h4,    32'h0,    1'b0, 4'd5},  // R5 mask alone no raise
      {1'b0, 8'h04, 32'h0,    32'h4,    1'b0, 4'd5},
      {1'b1, 8'h08, 32'h0,    32'h0,    1'b1, 4'd2},  // R2 empty post raises
      {1'b1, 8'h04, 32'h0,    32'h0,    1'b1, 4'd5},  // R5 mask alone no drop
      {1'b1, 8'h0C, 32'h5,    32'h0,    1'b1, 4'd4},  // R4 mask 0, hold
      {1'b0, 8'h00, 32'h0,    32'h0,    1'b1, 4'd4},
      {1'b1, 8'h04, 32'h1,    32'h0,    1'b1, 4'd5},
      {1'b1, 8'h08, 32'h3,    32'h0,    1'b1, 4'd2},
      {1'b1, 8'h0C, 32'h1,    32'h0,    1'b1, 4'd4},  // R4 pending left, hold
      {1'b0, 8'h00, 32'h0,    32'h2,    1'b1, 4'd4},
      {1'b1, 8'h0C, 32'h2,    32'h0,    1'b0, 4'd4},  // R4 drop
      {1'b0, 8'h08, 32'h0,    32'h0,    1'b0, 4'd7},  // R7
      {1'b0, 8'h0C, 32'h0,    32'h0,    1'b0, 4'd7},  // R7
      {1'b1, 8'h00, 32'hFFFF, 32'h0,    1'b0, 4'd6},  // R6 ignored
      {1'b0, 8'h00, 32'h0,    32'h0,    1'b0, 4'd6},
      {1'b1, 8'h20, 32'hA0A0, 32'h0,    1'b0, 4'd8},  // R8
      {1'b1, 8'h3C, 32'hB7B7, 32'h0,    1'b0, 4'd8},
      {1'b1, 8'h2C, 32'hC3C3, 32'h0,    1'b0, 4'd8},
      {1'b0, 8'h20, 32'h0,    32'hA0A0, 1'b0, 4'd8},
      {1'b0, 8'h3C, 32'h0,    32'hB7B7, 1'b0, 4'd8},
      {1'b0, 8'h2C, 32'h0,    32'hC3C3, 1'b0, 4'd8},
      {1'b0, 8'h28, 32'h0,    32'h0,    1'b0, 4'd8},
      {1'b1, 8'h40, 32'hDEAD, 32'h0,    1'b0, 4'd9},  // R9
      {1'b0, 8'h40, 32'h0,    32'h0,    1'b0, 4'd9},
      {1'b1, 8'h3D, 32'h7777, 32'h0,    1'b0, 4'd9},
      {1'b0, 8'h3C, 32'h0,    32'hB7B7, 1'b0, 4'd9},
      {1'b1, 8'h10, 32'h1234, 32'h0,    1'b0, 4'd9},
      {1'b0, 8'h10, 32'h0,    32'h0,    1'b0, 4'd9},
      {1'b0, 8'h04, 32'h0,    32'h1,    1'b0, 4'd9},
      {1'b0, 8'h00, 32'h0,    32'h0,    1'b0, 4'd9},
      {1'b1, 8'h08, 32'h8,    32'h0,    1'b0, 4'd3},  // R3 masked-off bit
      {1'b1, 8'h04, 32'h8,    32'h0,    1'b0, 4'd5},  // R5
      {1'b1, 8'h0C, 32'h0,    32'h0,    1'b0, 4'd4},  // R4 pending nonzero
      {1'b1, 8'h08, 32'h0,    32'h0,    1'b1, 4'd2}   // R2
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] exp_rd, input bit exp_irq, input string req);
      @(negedge clk);
      wr_en = wr; addr = a; wdata = d;
      #1;
      if (!wr) check(rdata === exp_rd, req, rdata, exp_rd);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      check(irq === exp_irq, req, {31'b0, irq}, {31'b0, exp_irq});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check(irq === 1'b0 && guest_err === 1'b0, "R1", {30'b0, irq, guest_err}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         do_op(VEC[i][77], VEC[i][76:69], VEC[i][68:37], VEC[i][36:5], VEC[i][4],
               $sformatf("R%0d", VEC[i][3:0]));
      end

      // R6: guest_err pulses exactly one cycle
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h00; wdata = 32'h1;
      @(posedge clk); #1; wr_en = 1'b0; addr = 8'h04;
      check(guest_err === 1'b1, "R6", {31'b0, guest_err}, 32'h1);
      @(posedge clk); #1;
      check(guest_err === 1'b0, "R6", {31'b0, guest_err}, 32'h0);

      // R1: reset in mid-operation clears everything
      do_op(1'b1, 8'h30, 32'h11, 32'h0, 1'b1, "R1");
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      check(irq === 1'b0, "R1", {31'b0, irq}, 32'h0);
      do_op(1'b0, 8'h30, 32'h0, 32'h0, 1'b0, "R1");
      do_op(1'b0, 8'h04, 32'h0, 32'h0, 1'b0, "R1");
      do_op(1'b0, 8'h00, 32'h0, 32'h0, 1'b0, "R1");

      // R8: every mailbox index in turn
      for (int k = 0; k < 8; k++)
         do_op(1'b1, 8'(8'h20 + 4 * k), 32'hF00 + k, 32'h0, 1'b0, "R8");
      for (int k = 0; k < 8; k++)
         do_op(1'b0, 8'(8'h20 + 4 * k), 32'h0, 32'hF00 + k, 1'b0, "R8");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule